// File: doc/BRIEF.md
# Overlapping Register Window File

This block is an integer register file whose 32 architectural register numbers are steered onto a larger physical array through a current window pointer. Registers 0 to 7 are globals that every window shares. Registers 8 to 15 are the window's outs, 16 to 23 its locals and 24 to 31 its ins. Neighbouring windows overlap: the ins of window w and the outs of window (w+1) mod N are the same physical registers. A caller places arguments in its outs, moves the pointer down by one, and the callee finds them in its ins without any copy.

Two combinational read ports and one clocked write port take 5-bit architectural numbers. A save request moves the pointer down by one and a restore request moves it up by one, both modulo the window count N. Before each move, the block checks the target window's bit in a window invalid mask. If that bit is set, the block raises a one-cycle overflow or underflow trap and leaves the pointer unchanged. A control port loads the pointer and the mask directly, and both are visible on outputs. Physical storage holds 8 globals plus 16 registers per window.

Top module: `regwin_file`

## Requirements
- R1: While reset is asserted and after it is released, the window pointer is 0, the mask is 0, both trap outputs are low and every register reads 0.
- R2: Register 0 reads as 0 on both read ports, and a write to it has no effect.
- R3: Registers 0 to 7 address the same storage in every window, so a value written under one pointer reads back unchanged under any other pointer.
- R4: Registers 24 to 31 (ins, index k = number − 24) of window w are the same storage as registers 8 to 15 (outs, index k = number − 8) of window (w+1) mod N. This holds for a write through either name and includes the wrap from window N−1 to window 0.
- R5: Registers 16 to 23 (locals) are private to each window, and outs are private apart from the overlap in R4. A write to a local in one window is not visible in another window's locals.
- R6: A save request with no control pointer write sets the pointer to (cwp−1) mod N on the next edge when mask bit (cwp−1) mod N is 0, so window 0 steps to window N−1.
- R7: A restore request with no save and no control pointer write sets the pointer to (cwp+1) mod N when mask bit (cwp+1) mod N is 0, so window N−1 steps to window 0.
- R8: A save whose target window has its mask bit set leaves the pointer unchanged and drives ovf_trap_o high for exactly the one cycle after the request edge.
- R9: A restore whose target window has its mask bit set leaves the pointer unchanged and drives unf_trap_o high for exactly the one cycle after the request edge.
- R10: When save and restore are requested together, only the save takes effect, and the two traps are never high together.
- R11: A control pointer write loads a value below N and takes precedence over a save or restore in the same cycle, which are then dropped without a trap. A value of N or more leaves the pointer unchanged.
- R12: Bit i of the mask belongs to window i. A control mask write stores bits 0 to N−1, and mask bits N and above read 0. A save or restore checks the mask as it stood before any mask write in the same cycle.
- R13: Reads are combinational and writes take effect at the rising edge. A read of a register being written in the same cycle returns the old value. A write issued in the same cycle as a save lands in the window that was current before the save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 5 | Read port A architectural register number |
| rd_a_data_o | output | XLEN | Read port A data |
| rd_b_addr_i | input | 5 | Read port B architectural register number |
| rd_b_data_o | output | XLEN | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write architectural register number |
| wr_data_i | input | XLEN | Write data |
| save_i | input | 1 | Save request (pointer down) |
| restore_i | input | 1 | Restore request (pointer up) |
| ctl_cwp_we_i | input | 1 | Control load of window pointer |
| ctl_cwp_i | input | 5 | Window pointer load value |
| ctl_wim_we_i | input | 1 | Control load of invalid mask |
| ctl_wim_i | input | 32 | Invalid mask load value |
| cwp_o | output | 5 | Current window pointer |
| wim_o | output | 32 | Window invalid mask, bits N and above zero |
| ovf_trap_o | output | 1 | One-cycle overflow trap pulse |
| unf_trap_o | output | 1 | One-cycle underflow trap pulse |

## Verification
The bench targets the two wrap points: the save from window 0 to window N−1 and the restore from N−1 to 0. A design with an off-by-one modulo would land in a nonexistent window or stick at the boundary. It checks the overlap in both directions, including ins of window N−1 against outs of window 0, because a mapping that adds where it should subtract leaves arguments in a window the callee never sees. It sets mask bits so that saves and restores are refused, and checks that the pointer holds and the trap lasts one cycle; a design that moves anyway or leaves the trap high would fail here. Further cases cover same-cycle collisions: a read against a write, a write against a save, and a mask write against a save. Others cover control-write precedence and an out-of-range pointer load, which a design lacking either check would accept.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int REG_AW    = 5;
  localparam int GLB_CNT   = 8;
  localparam int GRP_SIZE  = 8;
  localparam int WIN_SLOTS = 16;
  localparam int OUT_OFS   = 8;

  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;

  function automatic grp_e grp_of(input logic [REG_AW-1:0] arch);
    return grp_e'(arch[REG_AW-1:REG_AW-2]);
  endfunction
endpackage

// File: rtl/regwin_map.sv
module regwin_map
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PAW  = 8
) (
  input  logic [CW-1:0]     cwp_i,
  input  logic [REG_AW-1:0] arch_i,
  output logic [PAW-1:0]    phys_o
);
  int k;
  int cur;
  int nxt;
  int slot;

  always_comb begin
    k    = int'(arch_i[2:0]);
    cur  = int'(cwp_i);
    nxt  = (cur == NWIN - 1) ? 0 : cur + 1;
    slot = k;
    unique case (grp_of(arch_i))
      GRP_GLB: slot = k;
      GRP_OUT: slot = GLB_CNT + WIN_SLOTS * cur + OUT_OFS + k;
      GRP_LOC: slot = GLB_CNT + WIN_SLOTS * cur + k;
      GRP_IN:  slot = GLB_CNT + WIN_SLOTS * nxt + OUT_OFS + k; // ins alias next window's outs
      default: slot = k;
    endcase
    phys_o = PAW'(slot);
  end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int NREG = 136,
  parameter int XLEN = 32,
  parameter int NRD  = 2,
  parameter int PAW  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][PAW-1:0]  rd_addr_i,
  output logic [NRD-1:0][XLEN-1:0] rd_data_o,
  input  logic                     wr_en_i,
  input  logic [PAW-1:0]           wr_addr_i,
  input  logic [XLEN-1:0]          wr_data_i
);
  logic [NREG*XLEN-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign flat[XLEN-1:0] = '0;
    end else begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_en_i && (wr_addr_i == PAW'(i))) q <= wr_data_i;
      end
      assign flat[i*XLEN +: XLEN] = q;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (int'(rd_addr_i[p]) < NREG) rd_data_o[p] = flat[int'(rd_addr_i[p])*XLEN +: XLEN];
      else rd_data_o[p] = '0;
    end
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWIN = 8,
  parameter int CW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            cwp_we_i,
  input  logic [4:0]      cwp_i,
  input  logic            wim_we_i,
  input  logic [31:0]     wim_i,
  output logic [CW-1:0]   cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [CW-1:0]   cwp_q;
  logic [NWIN-1:0] wim_q;
  logic [CW-1:0]   cwp_dec;
  logic [CW-1:0]   cwp_inc;
  logic            load_ok;

  always_comb begin
    cwp_dec = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
    cwp_inc = (int'(cwp_q) == NWIN - 1) ? '0 : cwp_q + 1'b1;
    load_ok = int'(cwp_i) < NWIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (cwp_we_i) begin
        if (load_ok) cwp_q <= cwp_i[CW-1:0];
      end else if (save_i) begin
        if (wim_q[cwp_dec]) ovf_o <= 1'b1;
        else cwp_q <= cwp_dec;
      end else if (restore_i) begin
        if (wim_q[cwp_inc]) unf_o <= 1'b1;
        else cwp_q <= cwp_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wim_q <= '0;
    else if (wim_we_i) wim_q <= wim_i[NWIN-1:0];
  end

  assign cwp_o = cwp_q;
  assign wim_o = wim_q;
endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      rd_a_addr_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [4:0]      rd_b_addr_i,
  output logic [XLEN-1:0] rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [4:0]      wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            ctl_cwp_we_i,
  input  logic [4:0]      ctl_cwp_i,
  input  logic            ctl_wim_we_i,
  input  logic [31:0]     ctl_wim_i,
  output logic [4:0]      cwp_o,
  output logic [31:0]     wim_o,
  output logic            ovf_trap_o,
  output logic            unf_trap_o
);
  localparam int NREG  = GLB_CNT + WIN_SLOTS * NWIN;
  localparam int PAW   = $clog2(NREG);
  localparam int CW    = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int NPORT = 3; // two reads, one write

  logic [CW-1:0]                cwp_q;
  logic [NWIN-1:0]              wim_q;
  logic [NPORT-1:0][REG_AW-1:0] arch;
  logic [NPORT-1:0][PAW-1:0]    phys;
  logic [1:0][XLEN-1:0]         rd_data;
  logic                         wr_en_eff;

  assign arch[0] = rd_a_addr_i;
  assign arch[1] = rd_b_addr_i;
  assign arch[2] = wr_addr_i;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    regwin_map #(.NWIN(NWIN), .CW(CW), .PAW(PAW)) u_map (
      .cwp_i (cwp_q),
      .arch_i(arch[g]),
      .phys_o(phys[g])
    );
  end

  assign wr_en_eff = wr_en_i && (wr_addr_i != '0);

  regwin_store #(.NREG(NREG), .XLEN(XLEN), .NRD(2), .PAW(PAW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i({phys[1], phys[0]}),
    .rd_data_o(rd_data),
    .wr_en_i  (wr_en_eff),
    .wr_addr_i(phys[2]),
    .wr_data_i(wr_data_i)
  );

  regwin_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .save_i   (save_i),
    .restore_i(restore_i),
    .cwp_we_i (ctl_cwp_we_i),
    .cwp_i    (ctl_cwp_i),
    .wim_we_i (ctl_wim_we_i),
    .wim_i    (ctl_wim_i),
    .cwp_o    (cwp_q),
    .wim_o    (wim_q),
    .ovf_o    (ovf_trap_o),
    .unf_o    (unf_trap_o)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign cwp_o       = 5'(cwp_q);
  assign wim_o       = 32'(wim_q);
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [4:0]      rd_a_addr_i,
  input logic [XLEN-1:0] rd_a_data_o,
  input logic [4:0]      rd_b_addr_i,
  input logic [XLEN-1:0] rd_b_data_o,
  input logic            save_i,
  input logic            restore_i,
  input logic            ctl_cwp_we_i,
  input logic [4:0]      cwp_o,
  input logic [31:0]     wim_o,
  input logic            ovf_trap_o,
  input logic            unf_trap_o
);
  logic [4:0] dec;
  logic [4:0] inc;

  always_comb begin
    dec = (cwp_o == 5'd0) ? 5'(NWIN - 1) : cwp_o - 5'd1;
    inc = (int'(cwp_o) == NWIN - 1) ? 5'd0 : cwp_o + 5'd1;
  end

  AST_R0_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == 5'd0) |-> (rd_a_data_o == '0)); // R2
  AST_R0_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == 5'd0) |-> (rd_b_data_o == '0)); // R2
  AST_SAVE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !ctl_cwp_we_i && !wim_o[dec]) |=> (cwp_o == $past(dec))); // R6
  AST_RESTORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !ctl_cwp_we_i && !wim_o[inc]) |=> (cwp_o == $past(inc))); // R7
  AST_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !ctl_cwp_we_i && wim_o[dec]) |=> (ovf_trap_o && $stable(cwp_o))); // R8
  AST_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !ctl_cwp_we_i && wim_o[inc]) |=> (unf_trap_o && $stable(cwp_o))); // R9
  AST_NO_DUAL_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ovf_trap_o, unf_trap_o}) <= 1); // R10
  AST_CWP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cwp_o) < NWIN); // R11
  AST_WIM_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (64'(wim_o) >> NWIN) == 64'd0); // R12
endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (.*);

// File: tb/regwin_file_bench.sv
module regwin_file_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;
  localparam int XLEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [4:0]      rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0, ctl_cwp_i = '0;
  logic [XLEN-1:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic            wr_en_i = 0, save_i = 0, restore_i = 0, ctl_cwp_we_i = 0, ctl_wim_we_i = 0;
  logic [31:0]     ctl_wim_i = '0, wim_o;
  logic [4:0]      cwp_o;
  logic            ovf_trap_o, unf_trap_o;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  regwin_file #(.NWIN(NWIN), .XLEN(XLEN)) u_regwin_file (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    rd_a_addr_i = a;
    #1;
    chk(req, rd_a_data_o, exp);
  endtask

  task automatic set_cwp(input logic [4:0] v);
    ctl_cwp_we_i = 1; ctl_cwp_i = v;
    tick();
    ctl_cwp_we_i = 0;
  endtask

  task automatic set_wim(input logic [31:0] v);
    ctl_wim_we_i = 1; ctl_wim_i = v;
    tick();
    ctl_wim_we_i = 0;
  endtask

  task automatic do_save();
    save_i = 1; tick(); save_i = 0;
  endtask

  task automatic do_restore();
    restore_i = 1; tick(); restore_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 wim", wim_o, 0);
    chk("R1 traps", {30'd0, ovf_trap_o, unf_trap_o}, 0);
    rd_chk("R1 r5", 5'd5, 0);
    rd_chk("R1 r20", 5'd20, 0);
  endtask

  task automatic t_zero();
    wr(5'd0, 32'hdead_beef);
    rd_chk("R2 port a", 5'd0, 0);
    rd_b_addr_i = 5'd0;
    #1;
    chk("R2 port b", rd_b_data_o, 0);
  endtask

  task automatic t_globals();
    set_cwp(5'd0);
    wr(5'd3, 32'h0000_0033);
    set_cwp(5'd5);
    rd_chk("R3 global across windows", 5'd3, 32'h33);
  endtask

  task automatic t_overlap();
    set_cwp(5'd2);
    wr(5'd8, 32'hA0A0_0001);
    set_cwp(5'd1);
    rd_chk("R4 in of w1 = out of w2", 5'd24, 32'hA0A0_0001);
    wr(5'd25, 32'hB0B0_0002);
    set_cwp(5'd2);
    rd_chk("R4 out of w2 sees in-write", 5'd9, 32'hB0B0_0002);
    set_cwp(5'd0);
    wr(5'd10, 32'hC0C0_0003);
    set_cwp(5'(NWIN - 1));
    rd_chk("R4 wrap in of N-1 = out of 0", 5'd26, 32'hC0C0_0003);
  endtask

  task automatic t_private();
    set_cwp(5'd3);
    wr(5'd16, 32'h1111_0003);
    wr(5'd12, 32'h2222_0003);
    set_cwp(5'd4);
    rd_chk("R5 local private", 5'd16, 0);
    rd_chk("R5 out private", 5'd12, 0);
    wr(5'd16, 32'h1111_0004);
    set_cwp(5'd3);
    rd_chk("R5 local kept", 5'd16, 32'h1111_0003);
  endtask

  task automatic t_save_restore();
    set_wim(0);
    set_cwp(5'd2);
    wr(5'd13, 32'h5A5A_0013);
    do_save();
    chk("R6 save 2->1", 32'(cwp_o), 1);
    rd_chk("R4 callee ins see caller outs", 5'd29, 32'h5A5A_0013);
    do_save();
    chk("R6 save 1->0", 32'(cwp_o), 0);
    do_save();
    chk("R6 save wraps 0->N-1", 32'(cwp_o), NWIN - 1);
    do_restore();
    chk("R7 restore wraps N-1->0", 32'(cwp_o), 0);
    do_restore();
    chk("R7 restore 0->1", 32'(cwp_o), 1);
  endtask

  task automatic t_overflow();
    set_wim(32'h0000_0008);
    chk("R12 mask readback", wim_o, 32'h8);
    set_cwp(5'd4);
    do_save();
    chk("R8 cwp held", 32'(cwp_o), 4);
    chk("R8 ovf pulse", {31'd0, ovf_trap_o}, 1);
    chk("R8 no unf", {31'd0, unf_trap_o}, 0);
    tick();
    chk("R8 ovf one cycle", {31'd0, ovf_trap_o}, 0);
  endtask

  task automatic t_underflow();
    set_wim(32'h0000_0020);
    set_cwp(5'd4);
    do_restore();
    chk("R9 cwp held", 32'(cwp_o), 4);
    chk("R9 unf pulse", {31'd0, unf_trap_o}, 1);
    tick();
    chk("R9 unf one cycle", {31'd0, unf_trap_o}, 0);
  endtask

  task automatic t_both();
    set_wim(0);
    set_cwp(5'd4);
    save_i = 1; restore_i = 1;
    tick();
    save_i = 0; restore_i = 0;
    chk("R10 save wins", 32'(cwp_o), 3);
    chk("R10 no trap", {30'd0, ovf_trap_o, unf_trap_o}, 0);
  endtask

  task automatic t_ctl();
    set_wim(32'h0000_0004);
    set_cwp(5'd3);
    ctl_cwp_we_i = 1; ctl_cwp_i = 5'd6; save_i = 1;
    tick();
    ctl_cwp_we_i = 0; save_i = 0;
    chk("R11 load beats save", 32'(cwp_o), 6);
    chk("R11 dropped save no trap", {31'd0, ovf_trap_o}, 0);
    set_cwp(5'd9);
    chk("R11 out-of-range load ignored", 32'(cwp_o), 6);
  endtask

  task automatic t_wim();
    set_wim(32'hFFFF_FFFF);
    chk("R12 upper mask bits zero", wim_o, 32'h0000_00FF);
    set_wim(0);
    set_cwp(5'd6);
    save_i = 1; ctl_wim_we_i = 1; ctl_wim_i = 32'h0000_0020;
    tick();
    save_i = 0; ctl_wim_we_i = 0;
    chk("R12 save uses old mask", 32'(cwp_o), 5);
    chk("R12 no trap on old mask", {31'd0, ovf_trap_o}, 0);
    chk("R12 new mask stored", wim_o, 32'h20);
  endtask

  task automatic t_rw_same();
    set_wim(0);
    set_cwp(5'd6);
    wr(5'd17, 32'h0000_0001);
    wr_en_i = 1; wr_addr_i = 5'd17; wr_data_i = 32'h0000_0002; rd_b_addr_i = 5'd17;
    #1;
    chk("R13 read-during-write old", rd_b_data_o, 32'h1);
    tick();
    wr_en_i = 0;
    chk("R13 new value after edge", rd_b_data_o, 32'h2);
    wr_en_i = 1; wr_addr_i = 5'd18; wr_data_i = 32'h0000_0077; save_i = 1;
    tick();
    wr_en_i = 0; save_i = 0;
    chk("R13 save with write", 32'(cwp_o), 5);
    do_restore();
    rd_chk("R13 write hit pre-save window", 5'd18, 32'h77);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_ni = 1;
    #1;
    t_reset();
    t_zero();
    t_globals();
    t_overlap();
    t_private();
    t_save_restore();
    t_overflow();
    t_underflow();
    t_both();
    t_ctl();
    t_wim();
    t_rw_same();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule